// File: doc/BRIEF.md
# Dual-Issue Warp Instruction Scheduler

This block is the issue stage of one streaming multiprocessor. Two schedulers share the resident warps: scheduler 0 takes the even warp ids and scheduler 1 takes the odd ones. For each warp, the block sees its two oldest instructions. Each instruction has a destination register and up to two source registers. In every cycle, each scheduler picks one warp that can issue. It then sends that warp's oldest instruction, and where possible the next one as well, to free 16-lane arithmetic pipes. Three pipes are shared between the two schedulers.

A 32-thread instruction enters its pipe as two half-warp beats in consecutive cycles. The pipe stays occupied for both beats. A per-warp scoreboard records the destinations that are in flight. Any instruction that touches one of those registers is held back until a writeback pulse for that warp and register clears it. The block upstream of the scheduler treats a high ready bit for a slot as consumption of that instruction at the next clock edge, and then shifts its queue.

Top module: `wsched_top`

## Requirements
- R1: While reset is held, no pipe is valid. In the first cycle after reset, every scoreboard is empty, so any valid oldest instruction may issue at once.
- R2: An instruction granted in cycle t (its ready bit high in t) appears on its pipe in cycle t+1 with beat 0 (threads 0-15). It appears on the same pipe in cycle t+2 with beat 1 (threads 16-31). Warp id and destination are unchanged between the beats.
- R3: A pipe that will carry a second beat in the next cycle is not granted. A pipe that is showing beat 1 may be granted again.
- R4: The second-oldest instruction (slot 1) issues only together with slot 0 in the same cycle. It is paired only if it does not read or write slot 0's destination. It is never issued alone.
- R5: An instruction whose destination, or any used source, matches a register that is marked in flight for its warp does not issue. If slot 0 is blocked, the warp does not issue.
- R6: Issue marks the instruction's destination as in flight in that warp's scoreboard. A writeback pulse (warp id, register) clears the mark from the next cycle on. A writeback for one warp does not affect any other warp.
- R7: A scheduler whose next warp is blocked issues from another warp it owns that can issue, in the same cycle.
- R8: Each scheduler selects round-robin among its warps that can issue. It starts after the warp it last issued from. After reset, the lowest warp id it owns comes first.
- R9: Scheduler 0 owns the even warp ids and scheduler 1 owns the odd ones. Each scheduler issues from at most one warp per cycle, and both may issue in the same cycle.
- R10: Each scheduler asks for one or two pipes. The scheduler that has priority takes the lowest-numbered free pipes first, and the other scheduler takes the lowest of the pipes that remain. Scheduler 0 has priority in the first cycle after reset, and priority alternates every cycle after that. Within a scheduler, slot 0 gets the lower pipe. A scheduler that receives only one pipe issues only slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | NUM_WARPS x 2 | Instruction present, per warp and slot (slot 0 = oldest) |
| ins_dst_i | input | NUM_WARPS x 2 x REG_W | Destination register |
| ins_src_a_i | input | NUM_WARPS x 2 x REG_W | First source register |
| ins_src_b_i | input | NUM_WARPS x 2 x REG_W | Second source register |
| ins_use_a_i | input | NUM_WARPS x 2 | First source is used |
| ins_use_b_i | input | NUM_WARPS x 2 | Second source is used |
| ins_ready_o | output | NUM_WARPS x 2 | Slot is issued (consumed) at the next edge |
| wb_valid_i | input | 1 | Writeback pulse |
| wb_warp_i | input | WID_W | Warp id of the writeback |
| wb_reg_i | input | REG_W | Register being retired |
| pipe_valid_o | output | NUM_PIPES | Pipe carries a beat this cycle |
| pipe_beat_o | output | NUM_PIPES | 0 = threads 0-15, 1 = threads 16-31 |
| pipe_warp_o | output | NUM_PIPES x WID_W | Warp id on the pipe |
| pipe_dst_o | output | NUM_PIPES x REG_W | Destination register on the pipe |

## Verification
The hardest case to reach is contention: both schedulers want two pipes in the same cycle while some pipes are still in their second beat. The outcome also depends on which scheduler holds priority in that cycle. The bench resets the block before each scenario, counts the cycles since reset to know the priority parity, and presents dual-issue pairs to an even warp and an odd warp in chosen even and odd cycles. It models the upstream queue shift after a partial issue, so that the remaining instruction meets three busy pipes in the next cycle and free pipes in the cycle after. The scoreboard cases are reached the same way: an instruction issues, a dependent instruction is held, a writeback addressed to the wrong warp is sent, and then the correct writeback is sent.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  typedef enum logic {BEAT_LO = 1'b0, BEAT_HI = 1'b1} beat_e;
  localparam int unsigned SLOTS  = 2;  // visible instructions per warp
  localparam int unsigned SCHEDS = 2;  // even / odd warp schedulers
endpackage

// File: rtl/wsched_sboard.sv
module wsched_sboard #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W    = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    set_i,
  input  logic [1:0][REG_W-1:0]         set_idx_i,
  input  logic                          clr_i,
  input  logic [REG_W-1:0]              clr_idx_i,
  output logic [NUM_REGS-1:0]           busy_o
);
  logic [NUM_REGS-1:0] busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (clr_i) busy_d[clr_idx_i] = 1'b0;
    // set wins over a same-cycle clear
    for (int s = 0; s < 2; s++)
      if (set_i[s]) busy_d[set_idx_i[s]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;

  assign busy_o = busy_q;
endmodule

// File: rtl/wsched_pick.sv
module wsched_pick #(
  parameter int unsigned LOCAL = 2,
  parameter int unsigned LOC_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LOCAL-1:0]  elig_i,
  input  logic              adv_i,
  output logic [LOC_W-1:0]  sel_o,
  output logic              any_o
);
  logic [LOC_W-1:0] last_q;

  always_comb begin
    int idx;
    sel_o = '0;
    any_o = 1'b0;
    // walk from farthest to nearest so the nearest eligible wins
    for (int off = LOCAL; off >= 1; off--) begin
      idx = (int'(last_q) + off) % LOCAL;
      if (elig_i[idx]) begin
        sel_o = LOC_W'(idx);
        any_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    last_q <= LOC_W'(LOCAL - 1);
    else if (adv_i) last_q <= sel_o;
endmodule

// File: rtl/wsched_alloc.sv
module wsched_alloc #(
  parameter int unsigned NUM_PIPES = 3
) (
  input  logic [NUM_PIPES-1:0] free_i,
  input  logic [1:0][1:0]      want_i,
  input  logic                 prio_i,
  output logic [NUM_PIPES-1:0] own_o,
  output logic [NUM_PIPES-1:0] own_sched_o,
  output logic [NUM_PIPES-1:0] own_slot_o,
  output logic [1:0][1:0]      gcnt_o
);
  always_comb begin
    logic [NUM_PIPES-1:0] left;
    logic sc;
    int n;
    own_o       = '0;
    own_sched_o = '0;
    own_slot_o  = '0;
    gcnt_o      = '0;
    left        = free_i;
    for (int pass = 0; pass < 2; pass++) begin
      sc = (pass == 0) ? prio_i : !prio_i;
      n  = 0;
      for (int i = 0; i < NUM_PIPES; i++) begin
        if (left[i] && n < int'(want_i[sc])) begin
          own_o[i]       = 1'b1;
          own_sched_o[i] = sc;
          own_slot_o[i]  = n[0];
          left[i]        = 1'b0;
          n++;
        end
      end
      gcnt_o[sc] = 2'(n);
    end
  end
endmodule

// File: rtl/wsched_top.sv
module wsched_top
  import wsched_pkg::*;
#(
  parameter  int unsigned NUM_WARPS = 4,
  parameter  int unsigned NUM_REGS  = 16,
  parameter  int unsigned NUM_PIPES = 3,
  localparam int unsigned REG_W     = $clog2(NUM_REGS),
  localparam int unsigned WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_WARPS-1:0][1:0]           ins_valid_i,
  input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0] ins_dst_i,
  input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0] ins_src_a_i,
  input  logic [NUM_WARPS-1:0][1:0][REG_W-1:0] ins_src_b_i,
  input  logic [NUM_WARPS-1:0][1:0]           ins_use_a_i,
  input  logic [NUM_WARPS-1:0][1:0]           ins_use_b_i,
  output logic [NUM_WARPS-1:0][1:0]           ins_ready_o,
  input  logic                                wb_valid_i,
  input  logic [WID_W-1:0]                    wb_warp_i,
  input  logic [REG_W-1:0]                    wb_reg_i,
  output logic [NUM_PIPES-1:0]                pipe_valid_o,
  output logic [NUM_PIPES-1:0]                pipe_beat_o,
  output logic [NUM_PIPES-1:0][WID_W-1:0]     pipe_warp_o,
  output logic [NUM_PIPES-1:0][REG_W-1:0]     pipe_dst_o
);
  localparam int unsigned LOCAL = NUM_WARPS / SCHEDS;
  localparam int unsigned LOC_W = (LOCAL > 1) ? $clog2(LOCAL) : 1;

  function automatic logic hit(input logic [NUM_REGS-1:0] busy,
                               input logic [REG_W-1:0] dst,
                               input logic [REG_W-1:0] sa, input logic ua,
                               input logic [REG_W-1:0] sb, input logic ub);
    return busy[dst] || (ua && busy[sa]) || (ub && busy[sb]);
  endfunction

  logic [NUM_REGS-1:0]      busy [NUM_WARPS];
  logic [NUM_WARPS-1:0]     ok0, ok1;
  logic [LOC_W-1:0]         sel_loc  [SCHEDS];
  logic [WID_W-1:0]         sel_warp [SCHEDS];
  logic [SCHEDS-1:0]        any_ok;
  logic [SCHEDS-1:0][1:0]   want, gcnt;
  logic [NUM_PIPES-1:0]     free, own, own_sched, own_slot;
  logic                     prio_q;

  // per-warp hazard check and scoreboard
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic dep;
    assign dep = (ins_use_a_i[w][1] && ins_src_a_i[w][1] == ins_dst_i[w][0]) ||
                 (ins_use_b_i[w][1] && ins_src_b_i[w][1] == ins_dst_i[w][0]) ||
                 (ins_dst_i[w][1] == ins_dst_i[w][0]);
    assign ok0[w] = ins_valid_i[w][0] &&
                    !hit(busy[w], ins_dst_i[w][0], ins_src_a_i[w][0], ins_use_a_i[w][0],
                         ins_src_b_i[w][0], ins_use_b_i[w][0]);
    assign ok1[w] = ins_valid_i[w][1] && !dep &&
                    !hit(busy[w], ins_dst_i[w][1], ins_src_a_i[w][1], ins_use_a_i[w][1],
                         ins_src_b_i[w][1], ins_use_b_i[w][1]);

    wsched_sboard #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_sb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (ins_ready_o[w]),
      .set_idx_i (ins_dst_i[w]),
      .clr_i     (wb_valid_i && (wb_warp_i == WID_W'(w))),
      .clr_idx_i (wb_reg_i),
      .busy_o    (busy[w])
    );
  end

  // per-scheduler warp selection
  for (genvar s = 0; s < SCHEDS; s++) begin : g_sch
    logic [LOCAL-1:0] elig, pair;
    always_comb
      for (int k = 0; k < LOCAL; k++) begin
        elig[k] = ok0[k*SCHEDS + s];
        pair[k] = ok1[k*SCHEDS + s];
      end

    wsched_pick #(.LOCAL(LOCAL), .LOC_W(LOC_W)) u_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .elig_i (elig),
      .adv_i  (gcnt[s] != 2'd0),
      .sel_o  (sel_loc[s]),
      .any_o  (any_ok[s])
    );

    assign sel_warp[s] = WID_W'(int'(sel_loc[s]) * SCHEDS + s);
    assign want[s]     = !any_ok[s] ? 2'd0 : (pair[sel_loc[s]] ? 2'd2 : 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prio_q <= 1'b0;
    else         prio_q <= !prio_q;

  wsched_alloc #(.NUM_PIPES(NUM_PIPES)) u_alloc (
    .free_i      (free),
    .want_i      (want),
    .prio_i      (prio_q),
    .own_o       (own),
    .own_sched_o (own_sched),
    .own_slot_o  (own_slot),
    .gcnt_o      (gcnt)
  );

  always_comb begin
    ins_ready_o = '0;
    for (int s = 0; s < SCHEDS; s++) begin
      if (gcnt[s] != 2'd0) ins_ready_o[sel_warp[s]][0] = 1'b1;
      if (gcnt[s] == 2'd2) ins_ready_o[sel_warp[s]][1] = 1'b1;
    end
  end

  // pipe beat registers
  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    logic              pv_q;
    beat_e             pb_q;
    logic [WID_W-1:0]  pw_q;
    logic [REG_W-1:0]  pd_q;
    logic [WID_W-1:0]  gw;

    assign gw      = sel_warp[own_sched[i]];
    assign free[i] = !(pv_q && pb_q == BEAT_LO);

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        pv_q <= 1'b0;
        pb_q <= BEAT_LO;
        pw_q <= '0;
        pd_q <= '0;
      end else if (own[i]) begin
        pv_q <= 1'b1;
        pb_q <= BEAT_LO;
        pw_q <= gw;
        pd_q <= ins_dst_i[gw][own_slot[i]];
      end else if (pv_q && pb_q == BEAT_LO) begin
        pb_q <= BEAT_HI;
      end else begin
        pv_q <= 1'b0;
      end

    assign pipe_valid_o[i] = pv_q;
    assign pipe_beat_o[i]  = pb_q;
    assign pipe_warp_o[i]  = pw_q;
    assign pipe_dst_o[i]   = pd_q;
  end
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int unsigned NUM_WARPS = 4,
  parameter int unsigned NUM_PIPES = 3,
  parameter int unsigned REG_W     = 4,
  parameter int unsigned WID_W     = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_WARPS-1:0][1:0]       ins_ready_o,
  input logic [NUM_PIPES-1:0]            pipe_valid_o,
  input logic [NUM_PIPES-1:0]            pipe_beat_o,
  input logic [NUM_PIPES-1:0][WID_W-1:0] pipe_warp_o,
  input logic [NUM_PIPES-1:0][REG_W-1:0] pipe_dst_o
);
  logic [NUM_WARPS-1:0] even_take, odd_take;
  logic [2*NUM_WARPS-1:0] all_take;

  always_comb begin
    even_take = '0;
    odd_take  = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (w % 2 == 0) even_take[w] = ins_ready_o[w][0];
      else            odd_take[w]  = ins_ready_o[w][0];
      all_take[2*w]   = ins_ready_o[w][0];
      all_take[2*w+1] = ins_ready_o[w][1];
    end
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
    // R4
    pair_in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ins_ready_o[w][1] |-> ins_ready_o[w][0]);
  end

  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_p
    // R2
    two_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pipe_valid_o[i] && !pipe_beat_o[i]) |=>
      (pipe_valid_o[i] && pipe_beat_o[i] && $stable(pipe_warp_o[i]) && $stable(pipe_dst_o[i])));
    // R3
    beat_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pipe_valid_o[i] && pipe_beat_o[i]) |-> $past(pipe_valid_o[i] && !pipe_beat_o[i]));
    // R2
    beat_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pipe_valid_o[i] && !pipe_beat_o[i]) |-> $past(|all_take));
  end

  // R9
  one_warp_per_sched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(even_take) && $onehot0(odd_take));
  // R10
  grant_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(all_take) <= NUM_PIPES);
endmodule

bind wsched_top wsched_chk #(
  .NUM_WARPS (NUM_WARPS),
  .NUM_PIPES (NUM_PIPES),
  .REG_W     (REG_W),
  .WID_W     (WID_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ins_ready_o  (ins_ready_o),
  .pipe_valid_o (pipe_valid_o),
  .pipe_beat_o  (pipe_beat_o),
  .pipe_warp_o  (pipe_warp_o),
  .pipe_dst_o   (pipe_dst_o)
);

// File: tb/wsched_top_tb.sv
module wsched_top_tb_top;
  localparam int PERIOD = 10;
  localparam int NW = 4;
  localparam int NP = 3;
  localparam int RW = 4;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NW-1:0][1:0]         v, ua, ub, ready;
  logic [NW-1:0][1:0][RW-1:0] d, sa, sb;
  logic                       wb_v;
  logic [WW-1:0]              wb_w;
  logic [RW-1:0]              wb_r;
  logic [NP-1:0]              p_v, p_b;
  logic [NP-1:0][WW-1:0]      p_w;
  logic [NP-1:0][RW-1:0]      p_d;
  int nchk = 0, nerr = 0, cyc = 0;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  wsched_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .ins_valid_i(v), .ins_dst_i(d), .ins_src_a_i(sa), .ins_src_b_i(sb),
    .ins_use_a_i(ua), .ins_use_b_i(ub), .ins_ready_o(ready),
    .wb_valid_i(wb_v), .wb_warp_i(wb_w), .wb_reg_i(wb_r),
    .pipe_valid_o(p_v), .pipe_beat_o(p_b), .pipe_warp_o(p_w), .pipe_dst_o(p_d)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pchk(string req, int i, int beat, int w, int dst);
    chk({req, " pipe valid"}, int'(p_v[i]), 1);
    chk({req, " pipe beat"}, int'(p_b[i]), beat);
    chk({req, " pipe warp"}, int'(p_w[i]), w);
    chk({req, " pipe dst"}, int'(p_d[i]), dst);
  endtask

  task automatic clr_in();
    v = '0; ua = '0; ub = '0; d = '0; sa = '0; sb = '0;
  endtask

  // a or b negative means that source is unused
  task automatic put(int w, int s, int dst, int a, int b);
    v[w][s]  = 1'b1;
    d[w][s]  = RW'(dst);
    ua[w][s] = (a >= 0);
    sa[w][s] = RW'(a < 0 ? 0 : a);
    ub[w][s] = (b >= 0);
    sb[w][s] = RW'(b < 0 ? 0 : b);
  endtask

  task automatic reset_dut();
    rst_ni = 1'b0;
    clr_in();
    wb_v = 1'b0; wb_w = '0; wb_r = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic edge_after();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; clr_in(); wb_v = 1'b0;
    @(negedge clk); #1;
    chk("R1 no pipe valid in reset", int'(p_v), 0);
    reset_dut();
    put(0, 0, 3, 5, 7); put(1, 0, 3, 5, 7);
    #1;
    chk("R1 warp0 issues after reset", int'(ready[0]), 1);
    chk("R9 warp1 issues same cycle", int'(ready[1]), 1);
    edge_after(); clr_in();
    @(negedge clk); #1;
    pchk("R9 even warp pipe0", 0, 0, 0, 3);
    pchk("R9 odd warp pipe1", 1, 0, 1, 3);
  endtask

  task automatic t_dual();
    reset_dut();
    put(0, 0, 1, 2, -1); put(0, 1, 4, 5, -1);
    #1;
    chk("R4 independent pair", int'(ready[0]), 3);
    edge_after(); clr_in();
    @(negedge clk); #1;
    pchk("R2 beat0 slot0", 0, 0, 0, 1);
    pchk("R2 beat0 slot1", 1, 0, 0, 4);
    chk("R2 pipe2 idle", int'(p_v[2]), 0);
    @(negedge clk); #1;
    pchk("R2 beat1 slot0", 0, 1, 0, 1);
    pchk("R2 beat1 slot1", 1, 1, 0, 4);
    @(negedge clk); #1;
    chk("R2 pipes idle after beats", int'(p_v), 0);
  endtask

  task automatic t_dep();
    reset_dut();
    put(0, 0, 6, -1, -1); put(0, 1, 8, -1, 6);
    #1;
    chk("R4 read-after-write not paired", int'(ready[0]), 1);
    put(0, 1, 6, -1, -1);
    #1;
    chk("R4 same destination not paired", int'(ready[0]), 1);
  endtask

  task automatic t_score();
    reset_dut();
    put(0, 0, 9, -1, -1);
    #1;
    chk("R6 first write issues", int'(ready[0]), 1);
    edge_after(); clr_in();
    @(negedge clk);
    put(0, 0, 11, 9, -1); put(0, 1, 2, -1, -1); put(2, 0, 10, 9, -1);
    #1;
    chk("R5 dependent oldest blocked", int'(ready[0]), 0);
    chk("R7 other warp issues", int'(ready[2]), 1);
    edge_after(); v[2] = '0;
    @(negedge clk);
    wb_v = 1'b1; wb_w = 2'd2; wb_r = 4'd9;
    #1;
    chk("R5 still blocked", int'(ready[0]), 0);
    edge_after(); wb_v = 1'b0;
    @(negedge clk); #1;
    chk("R6 writeback of other warp no effect", int'(ready[0]), 0);
    wb_v = 1'b1; wb_w = 2'd0; wb_r = 4'd9;
    edge_after(); wb_v = 1'b0;
    @(negedge clk); #1;
    chk("R6 cleared after writeback", int'(ready[0]), 3);
  endtask

  task automatic t_rr();
    reset_dut();
    put(0, 0, 1, -1, -1); put(2, 0, 2, -1, -1);
    #1;
    chk("R8 lowest warp first", int'(ready[0]), 1);
    chk("R8 other waits", int'(ready[2]), 0);
    edge_after(); v[0] = '0;
    @(negedge clk); #1;
    chk("R8 second warp next", int'(ready[2]), 1);
    edge_after(); v[2] = '0;
    @(negedge clk); #1;
    pchk("R3 busy pipe0 skipped", 1, 0, 2, 2);
    pchk("R2 pipe0 second beat", 0, 1, 0, 1);
    put(0, 0, 3, -1, -1); put(2, 0, 4, -1, -1);
    #1;
    chk("R8 wraps to first", int'(ready[0]), 1);
    chk("R8 wraps other waits", int'(ready[2]), 0);
  endtask

  task automatic t_prio_even();
    reset_dut();
    put(0, 0, 1, -1, -1); put(0, 1, 2, -1, -1);
    put(1, 0, 3, -1, -1); put(1, 1, 4, -1, -1);
    #1;
    chk("R10 priority sched gets two", int'(ready[0]), 3);
    chk("R10 other gets one", int'(ready[1]), 1);
    edge_after();
    v[0] = '0; d[1][0] = 4'd4; v[1][1] = 1'b0;
    @(negedge clk); #1;
    pchk("R10 pipe0", 0, 0, 0, 1);
    pchk("R10 pipe1", 1, 0, 0, 2);
    pchk("R10 pipe2", 2, 0, 1, 3);
    chk("R3 all pipes busy", int'(ready[1]), 0);
    @(negedge clk); #1;
    chk("R3 pipe2 beat1", int'(p_b[2]), 1);
    chk("R3 pipes free again", int'(ready[1]), 1);
  endtask

  task automatic t_prio_odd();
    reset_dut();
    @(negedge clk);
    put(0, 0, 1, -1, -1); put(0, 1, 2, -1, -1);
    put(1, 0, 3, -1, -1); put(1, 1, 4, -1, -1);
    #1;
    chk("R10 odd cycle sched1 two", int'(ready[1]), 3);
    chk("R10 odd cycle sched0 one", int'(ready[0]), 1);
    edge_after(); clr_in();
    @(negedge clk); #1;
    pchk("R10 sched1 pipe0", 0, 0, 1, 3);
    pchk("R10 sched1 pipe1", 1, 0, 1, 4);
    pchk("R10 sched0 pipe2", 2, 0, 0, 1);
  endtask

  initial begin
    clr_in(); wb_v = 1'b0; wb_w = '0; wb_r = '0;
    t_reset();
    t_dual();
    t_dep();
    t_score();
    t_rr();
    t_prio_even();
    t_prio_odd();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    nchk++; nerr++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule